// File: doc/BRIEF.md
# Dual-Channel Conversion Result Latch with Data-Ready Strobe

This block sits between two converter channels and a serial read port. Each channel raises a one-cycle done strobe with a 24-bit result. The block keeps each channel's newest result in a capture register. A 2-bit mode input decides when a captured pair is published to the reader, and every publication raises a one-cycle active-low data-ready strobe.

The data-ready output is modelled as an output enable plus a value. When no strobe is active, the line either floats (enable low) or is driven high, as chosen by a drive-high input. Floating lets several blocks share one line through a pull-up.

A second register stage freezes the published pair for the length of a serial read. The read is bracketed by a read-start and a read-done handshake. Results published during a read wait in the first stage, newest wins, and become visible once the read ends. Strobes are not held back by a read in progress. The block has no chip-select input.

Top module: `drdy_latch`

## Requirements
- R1: While `rst_n` is low, `drdy_val` is 1, `drdy_oe` equals `drive_hi`, and both read words are zero.
- R2: In any cycle without a strobe, `drdy_val` is 1 and `drdy_oe` equals `drive_hi`. A 0 on `drive_hi` means high-impedance and a 1 means driven high.
- R3: A publication on clock edge t gives `drdy_oe`=1 and `drdy_val`=0 for exactly the one cycle that follows edge t.
- R4: Mode 2'b00 publishes only once both channels have completed since the last publication, with both on the same edge counting as well. The strobe follows the later channel, and the pair holds each channel's newest result.
- R5: Mode 2'b01 publishes on every channel-0 done and never on a lone channel-1 done. The pair carries the newest result of each channel.
- R6: Mode 2'b10 publishes on every channel-1 done and never on a lone channel-0 done.
- R7: Mode 2'b11 publishes on every done of either channel, without alignment.
- R8: From the edge that samples `rd_start` (no read active) until the edge that samples `rd_done`, `rd_word0` and `rd_word1` stay frozen at the pair published before the start.
- R9: After the edge that samples `rd_done`, the read words show the newest published pair, including pairs published during the read.
- R10: Publications during a read still produce a data-ready strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Publication mode (00 aligned, 01 ch0, 10 ch1, 11 either) |
| drive_hi | input | 1 | 1: drive the idle line high; 0: float it |
| ch0_done | input | 1 | Channel 0 result valid strobe |
| ch0_data | input | W | Channel 0 result |
| ch1_done | input | 1 | Channel 1 result valid strobe |
| ch1_data | input | W | Channel 1 result |
| rd_start | input | 1 | Serial read begins |
| rd_done | input | 1 | Last bit of serial read shifted out |
| drdy_oe | output | 1 | Data-ready output enable |
| drdy_val | output | 1 | Data-ready driven value (0 = strobe) |
| rd_word0 | output | W | Channel 0 word presented to the reader |
| rd_word1 | output | W | Channel 1 word presented to the reader |

## Verification
The assertions rely on publications never falling on two consecutive edges, so that a strobe is always followed by an idle cycle. They also rely on `rd_done` arriving only while a read is open. The stimulus keeps every done strobe one cycle long and spaces strobes of either channel at least two cycles apart. Reads are always opened with `rd_start` and closed with a single `rd_done`. Mode and drive-high changes are made only while no result is waiting in the first stage.

// File: rtl/drdy_latch.sv
module drdy_latch #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         drive_hi,
  input  logic         ch0_done,
  input  logic [W-1:0] ch0_data,
  input  logic         ch1_done,
  input  logic [W-1:0] ch1_data,
  input  logic         rd_start,
  input  logic         rd_done,
  output logic         drdy_oe,
  output logic         drdy_val,
  output logic [W-1:0] rd_word0,
  output logic [W-1:0] rd_word1
);
  logic [W-1:0] cap0, cap1, av0, av1, hold0, hold1;
  logic [W-1:0] lat0, lat1;
  logic         got0, got1, busy, pulse, rel;

  assign lat0 = ch0_done ? ch0_data : cap0;
  assign lat1 = ch1_done ? ch1_data : cap1;

  always_comb begin
    case (mode)
      2'b00:   rel = (got0 | ch0_done) & (got1 | ch1_done);
      2'b01:   rel = ch0_done;
      2'b10:   rel = ch1_done;
      default: rel = ch0_done | ch1_done;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap0 <= '0; cap1 <= '0;
      av0 <= '0; av1 <= '0;
      got0 <= 1'b0; got1 <= 1'b0;
      pulse <= 1'b0;
    end else begin
      cap0 <= lat0;
      cap1 <= lat1;
      got0 <= rel ? 1'b0 : (got0 | ch0_done);
      got1 <= rel ? 1'b0 : (got1 | ch1_done);
      pulse <= rel;
      if (rel) begin
        av0 <= lat0;
        av1 <= lat1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      hold0 <= '0; hold1 <= '0;
    end else if (busy) begin
      if (rd_done) busy <= 1'b0;
    end else if (rd_start) begin
      busy <= 1'b1;
      hold0 <= av0;
      hold1 <= av1;
    end
  end

  assign rd_word0 = busy ? hold0 : av0;
  assign rd_word1 = busy ? hold1 : av1;
  assign drdy_oe  = pulse | drive_hi;
  assign drdy_val = ~pulse;
endmodule

// File: rtl/drdy_latch_chk.sv
module drdy_latch_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         drive_hi,
  input logic         ch0_done,
  input logic         ch1_done,
  input logic         rd_done,
  input logic         drdy_oe,
  input logic         drdy_val,
  input logic [W-1:0] rd_word0,
  input logic [W-1:0] rd_word1,
  input logic         busy
);
  always @(negedge clk)
    if (!rst_n) assert_reset_idle_R1: assert (drdy_val && rd_word0 == '0 && rd_word1 == '0);

  assert_idle_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drdy_val |-> (drdy_oe == drive_hi));

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !drdy_val |-> drdy_oe ##1 drdy_val);

  assert_aligned_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !ch0_done && !ch1_done) |=> drdy_val);

  assert_ch0_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> (drdy_val != $past(ch0_done)));

  assert_ch1_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (drdy_val != $past(ch1_done)));

  assert_either_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && (ch0_done || ch1_done)) |=> !drdy_val);

  assert_read_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_done) |=> ($stable(rd_word0) && $stable(rd_word1)));
endmodule

bind drdy_latch drdy_latch_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .drive_hi(drive_hi),
  .ch0_done(ch0_done), .ch1_done(ch1_done), .rd_done(rd_done),
  .drdy_oe(drdy_oe), .drdy_val(drdy_val),
  .rd_word0(rd_word0), .rd_word1(rd_word1), .busy(busy)
);

// File: tb/drdy_latch_tb.sv
module drdy_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic drive_hi = 1'b0;
  logic ch0_done = 1'b0, ch1_done = 1'b0, rd_start = 1'b0, rd_done = 1'b0;
  logic [W-1:0] ch0_data = '0, ch1_data = '0;
  logic drdy_oe, drdy_val;
  logic [W-1:0] rd_word0, rd_word1;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit finished = 0;

  drdy_latch #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .drive_hi(drive_hi),
    .ch0_done(ch0_done), .ch0_data(ch0_data),
    .ch1_done(ch1_done), .ch1_data(ch1_data),
    .rd_start(rd_start), .rd_done(rd_done),
    .drdy_oe(drdy_oe), .drdy_val(drdy_val),
    .rd_word0(rd_word0), .rd_word1(rd_word1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_new0, m_new1, m_pub0, m_pub1, m_frz0, m_frz1;
  bit m_seen0, m_seen1, m_strobe, m_reading;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_new0 = 0; m_new1 = 0; m_pub0 = 0; m_pub1 = 0; m_frz0 = 0; m_frz1 = 0;
      m_seen0 = 0; m_seen1 = 0; m_strobe = 0; m_reading = 0;
    end else begin
      bit go;
      if (m_reading && rd_done) m_reading = 0;
      else if (!m_reading && rd_start) begin
        m_reading = 1; m_frz0 = m_pub0; m_frz1 = m_pub1;
      end
      if (ch0_done) begin m_new0 = int'(ch0_data); m_seen0 = 1; end
      if (ch1_done) begin m_new1 = int'(ch1_data); m_seen1 = 1; end
      if (mode == 2'b00) go = m_seen0 && m_seen1;
      else if (mode == 2'b01) go = ch0_done;
      else if (mode == 2'b10) go = ch1_done;
      else go = ch0_done || ch1_done;
      m_strobe = go;
      if (go) begin
        m_pub0 = m_new0; m_pub1 = m_new1; m_seen0 = 0; m_seen1 = 0;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int e0, e1;
    e0 = m_reading ? m_frz0 : m_pub0;
    e1 = m_reading ? m_frz1 : m_pub1;
    check(cur_req, "oe", int'(drdy_oe), int'(m_strobe | drive_hi));
    check(cur_req, "val", int'(drdy_val), int'(!m_strobe));
    check(cur_req, "word0", int'(rd_word0), e0);
    check(cur_req, "word1", int'(rd_word1), e1);
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe(bit c0, bit c1, int d0, int d1);
    @(posedge clk); #1;
    ch0_done = c0; ch1_done = c1;
    ch0_data = W'(d0); ch1_data = W'(d1);
    @(posedge clk); #1;
    ch0_done = 0; ch1_done = 0;
  endtask

  task automatic pulse_rd(bit start);
    @(posedge clk); #1;
    if (start) rd_start = 1; else rd_done = 1;
    @(posedge clk); #1;
    rd_start = 0; rd_done = 0;
  endtask

  initial begin
    cur_req = "R1";
    idle(3);
    @(negedge clk);
    check("R1", "reset val", int'(drdy_val), 1);
    check("R1", "reset word0", int'(rd_word0), 0);
    rst_n = 1;
    idle(2);

    cur_req = "R2";
    @(negedge clk); check("R2", "float oe", int'(drdy_oe), 0);
    drive_hi = 1; idle(1);
    @(negedge clk); check("R2", "driven oe", int'(drdy_oe), 1);

    cur_req = "R4";
    strobe(1, 0, 'h111111, 0); idle(1);
    @(negedge clk); check("R4", "no pulse on lone ch0", int'(drdy_val), 1);
    strobe(1, 0, 'h222222, 0); idle(1);
    strobe(0, 1, 0, 'h333333);
    @(negedge clk);
    check("R3", "pulse low", int'(drdy_val), 0);
    check("R4", "newest ch0", int'(rd_word0), 'h222222);
    check("R4", "ch1", int'(rd_word1), 'h333333);
    @(negedge clk); check("R3", "pulse one cycle", int'(drdy_val), 1);
    strobe(1, 1, 'h444444, 'h555555);
    @(negedge clk); check("R4", "same edge pair", int'(rd_word1), 'h555555);
    idle(2);

    drive_hi = 0;
    cur_req = "R5"; mode = 2'b01; idle(1);
    strobe(0, 1, 0, 'h0a0a0a);
    @(negedge clk); check("R5", "ch1 alone quiet", int'(drdy_val), 1);
    strobe(1, 0, 'h0b0b0b, 0);
    @(negedge clk);
    check("R5", "ch0 pulse", int'(drdy_val), 0);
    check("R5", "carries ch1 newest", int'(rd_word1), 'h0a0a0a);
    idle(2);

    cur_req = "R6"; mode = 2'b10; idle(1);
    strobe(1, 0, 'h0c0c0c, 0);
    @(negedge clk); check("R6", "ch0 alone quiet", int'(drdy_val), 1);
    strobe(0, 1, 0, 'h0d0d0d);
    @(negedge clk); check("R6", "ch1 pulse", int'(drdy_val), 0);
    idle(2);

    cur_req = "R7"; mode = 2'b11; drive_hi = 1; idle(1);
    strobe(1, 0, 'h0e0e0e, 0);
    @(negedge clk); check("R7", "ch0 pulse", int'(drdy_val), 0);
    idle(1);
    strobe(0, 1, 0, 'h0f0f0f);
    @(negedge clk); check("R7", "ch1 pulse", int'(drdy_val), 0);
    idle(2);

    cur_req = "R8";
    pulse_rd(1);
    strobe(1, 0, 'h123456, 0);
    @(negedge clk);
    check("R10", "pulse during read", int'(drdy_val), 0);
    check("R8", "frozen word0", int'(rd_word0), 'h0e0e0e);
    idle(1);
    strobe(0, 1, 0, 'h654321); idle(2);
    @(negedge clk); check("R8", "frozen word1", int'(rd_word1), 'h0f0f0f);
    cur_req = "R9";
    pulse_rd(0);
    @(negedge clk);
    check("R9", "newest word0", int'(rd_word0), 'h123456);
    check("R9", "newest word1", int'(rd_word1), 'h654321);
    idle(3);

    cur_req = "R1";
    rst_n = 0; idle(1);
    @(negedge clk); check("R1", "reset clears word1", int'(rd_word1), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule